// File: doc/BRIEF.md
# Lockable Register Command Decoder

This block sits behind a serial-bus slave front end. Each accepted byte write carries an address and a data byte. The block decodes that write into one of these targets:

- a four-byte alarm trip-point register;
- a four-bit configuration register;
- ten bytes of user memory;
- three command locations.

One command location requests a clear of the elapsed-time, total-time and event counters. The other two arm one-time locks. The block also serves byte reads from the same address space.

Each lock flag is set only by the same magic byte written twice in a row to its own location. Once set, a flag can never be cleared. The write lock protects the configuration and trip-point registers. The memory lock protects user memory. The clear request is passed on as a one-cycle pulse, and only when reset is enabled. Reset is enabled either by a configuration bit, or by an alternate-mapping bit together with a high level on an external enable pin. While the upstream bus reports busy, writes are refused and flagged.

Top module: `trec_cmd_decoder`

## Requirements
- R1: After reset, `trip_point`, `cfg_bits`, all user memory bytes and both lock flags are zero. No pulse output is asserted.
- R2: An accepted write to address 00h–03h sets byte n of `trip_point` (bits 8n+7..8n). A write to 04h stores data bits 3:0 in `cfg_bits`. The configuration bits are: bit0 alarm polarity, bit1 clear enable, bit2 pin-mapped enable, bit3 pulsed-output select. Both registers read back at their own addresses.
- R3: Addresses 0Ah–13h hold ten bytes of user memory that read back what was last written. Unmapped addresses read 00h.
- R4: A write of 55h to 1Dh makes `clr_pulse` high for one cycle, in the cycle after the write. This happens only if cfg bit1 is 1, or cfg bit2 is 1 with `rst_en_pin` high. Any other data byte, or a disabled clear, gives no pulse.
- R5: Two consecutive accepted writes of AAh to 1Eh set `wr_lock`. After that, writes to 00h–04h have no effect.
- R6: Two consecutive accepted writes of F0h to 1Fh set `mem_lock`. After that, writes to user memory have no effect.
- R7: `mem_lock` does not block writes to the trip-point or configuration registers. `wr_lock` does not block writes to user memory.
- R8: An accepted write to any other address, or with any other data, between the two magic writes restarts the sequence. A refused write does not restart it.
- R9: Once set, neither lock flag is cleared by any write, including a clear command or a write of other data to 1Eh or 1Fh.
- R10: The clear command still pulses `clr_pulse` while `wr_lock` is set, provided the enable condition of R4 holds.
- R11: Reads of 1Dh, 1Eh and 1Fh return 00h. A read of 04h returns `cfg_bits` in bits 3:0, `wr_lock` in bit 4 and `mem_lock` in bit 5. Written bits 7:4 of the configuration are ignored.
- R12: A write that arrives while `bus_busy` is high changes nothing and gives a one-cycle `wr_refused` pulse in the next cycle. An accepted write gives a one-cycle `wr_ack` pulse in the next cycle instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the bus front end |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data byte |
| bus_busy | input | 1 | Upstream busy; writes are refused while high |
| rst_en_pin | input | 1 | External clear-enable pin level |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Combinational read data |
| wr_ack | output | 1 | Accepted-write pulse, one cycle after the write |
| wr_refused | output | 1 | Refused-write pulse, one cycle after the write |
| clr_pulse | output | 1 | Counter clear request pulse |
| trip_point | output | 32 | Alarm trip-point value |
| cfg_bits | output | 4 | Configuration bits |
| wr_lock | output | 1 | Permanent configuration/trip write lock |
| mem_lock | output | 1 | Permanent user-memory write lock |

## Verification
The hardest state to reach from the ports is a half-armed lock sequence. It is invisible: no output shows that the first magic byte was seen. The bench reaches it by ordering the writes. It sends one magic write, then an intervening write, then one magic write, and confirms that the flag is still clear. A fourth magic write then sets the flag, which shows that the third write re-armed the sequence. A refused write placed between two magic writes shows, through the flag rising afterwards, that a refusal leaves the armed state alone. Because the locks are permanent, each lock scenario starts from a fresh reset.

// File: rtl/trec_cmd_pkg.sv
package trec_cmd_pkg;
    localparam int ADDR_W      = 5;
    localparam int DATA_W      = 8;
    localparam int TRIP_BYTES  = 4;
    localparam int TRIP_BASE   = 0;
    localparam int CFG_ADDR    = 4;
    localparam int CFG_W       = 4;
    localparam int UMEM_BYTES  = 10;
    localparam int UMEM_BASE   = 10;
    localparam int CLR_ADDR    = 29;
    localparam int WLK_ADDR    = 30;
    localparam int MLK_ADDR    = 31;
    localparam logic [7:0] CLR_KEY = 8'h55;
    localparam logic [7:0] WLK_KEY = 8'hAA;
    localparam logic [7:0] MLK_KEY = 8'hF0;

    typedef enum logic [1:0] {
        ARM_IDLE    = 2'd0,
        ARM_WL_HALF = 2'd1,
        ARM_ML_HALF = 2'd2
    } arm_state_e;
endpackage

// File: rtl/trec_lock_seq.sv
module trec_lock_seq
    import trec_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_acc,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_lock,
    output logic              mem_lock
);
    arm_state_e state_q, state_d;
    logic hit_wl, hit_ml;

    assign hit_wl = (wr_addr == ADDR_W'(WLK_ADDR)) && (wr_data == WLK_KEY);
    assign hit_ml = (wr_addr == ADDR_W'(MLK_ADDR)) && (wr_data == MLK_KEY);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARM_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (wr_acc) begin
            unique case (state_q)
                ARM_IDLE:    state_d = hit_wl ? ARM_WL_HALF :
                                       hit_ml ? ARM_ML_HALF : ARM_IDLE;
                ARM_WL_HALF: state_d = hit_ml ? ARM_ML_HALF : ARM_IDLE;
                ARM_ML_HALF: state_d = hit_wl ? ARM_WL_HALF : ARM_IDLE;
                default:     state_d = ARM_IDLE;
            endcase
        end
    end

    // outputs: sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_lock  <= 1'b0;
            mem_lock <= 1'b0;
        end else if (wr_acc) begin
            if (hit_wl && state_q == ARM_WL_HALF) wr_lock  <= 1'b1;
            if (hit_ml && state_q == ARM_ML_HALF) mem_lock <= 1'b1;
        end
    end
endmodule

// File: rtl/trec_regbank.sv
module trec_regbank
    import trec_cmd_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_acc,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        wr_lock,
    input  logic                        mem_lock,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [TRIP_BYTES*DATA_W-1:0] trip_q,
    output logic [CFG_W-1:0]            cfg_q,
    output logic [DATA_W-1:0]           umem_rd,
    output logic                        umem_hit
);
    logic [DATA_W-1:0] umem_q [UMEM_BYTES];

    for (genvar b = 0; b < TRIP_BYTES; b++) begin : g_trip
        always_ff @(posedge clk) begin
            if (!rst_n)
                trip_q[b*DATA_W +: DATA_W] <= '0;
            else if (wr_acc && !wr_lock && wr_addr == ADDR_W'(TRIP_BASE + b))
                trip_q[b*DATA_W +: DATA_W] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_acc && !wr_lock && wr_addr == ADDR_W'(CFG_ADDR))
            cfg_q <= wr_data[CFG_W-1:0];
    end

    for (genvar i = 0; i < UMEM_BYTES; i++) begin : g_umem
        always_ff @(posedge clk) begin
            if (!rst_n)
                umem_q[i] <= '0;
            else if (wr_acc && !mem_lock && wr_addr == ADDR_W'(UMEM_BASE + i))
                umem_q[i] <= wr_data;
        end
    end

    always_comb begin
        umem_rd  = '0;
        umem_hit = 1'b0;
        for (int i = 0; i < UMEM_BYTES; i++) begin
            if (rd_addr == ADDR_W'(UMEM_BASE + i)) begin
                umem_rd  = umem_q[i];
                umem_hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/trec_rd_mux.sv
module trec_rd_mux
    import trec_cmd_pkg::*;
(
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic [TRIP_BYTES*DATA_W-1:0] trip_q,
    input  logic [CFG_W-1:0]             cfg_q,
    input  logic                         wr_lock,
    input  logic                         mem_lock,
    input  logic [DATA_W-1:0]            umem_rd,
    input  logic                         umem_hit,
    output logic [DATA_W-1:0]            rd_data
);
    always_comb begin
        rd_data = '0;
        if (umem_hit) rd_data = umem_rd;
        for (int b = 0; b < TRIP_BYTES; b++) begin
            if (rd_addr == ADDR_W'(TRIP_BASE + b)) rd_data = trip_q[b*DATA_W +: DATA_W];
        end
        if (rd_addr == ADDR_W'(CFG_ADDR))
            rd_data = {{(DATA_W-CFG_W-2){1'b0}}, mem_lock, wr_lock, cfg_q};
        // command locations fall through to zero
    end
endmodule

// File: rtl/trec_cmd_decoder.sv
module trec_cmd_decoder
    import trec_cmd_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         bus_busy,
    input  logic                         rst_en_pin,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         wr_ack,
    output logic                         wr_refused,
    output logic                         clr_pulse,
    output logic [TRIP_BYTES*DATA_W-1:0] trip_point,
    output logic [CFG_W-1:0]             cfg_bits,
    output logic                         wr_lock,
    output logic                         mem_lock
);
    logic              wr_acc;
    logic              clr_ok;
    logic [DATA_W-1:0] umem_rd;
    logic              umem_hit;

    assign wr_acc = wr_en && !bus_busy;
    // bit1 clear enable, bit2 pin-mapped enable
    assign clr_ok = cfg_bits[1] || (cfg_bits[2] && rst_en_pin);

    trec_lock_seq u_lock (
        .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_lock(wr_lock), .mem_lock(mem_lock)
    );

    trec_regbank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_lock(wr_lock), .mem_lock(mem_lock),
        .rd_addr(rd_addr), .trip_q(trip_point), .cfg_q(cfg_bits),
        .umem_rd(umem_rd), .umem_hit(umem_hit)
    );

    trec_rd_mux u_rd (
        .rd_addr(rd_addr), .trip_q(trip_point), .cfg_q(cfg_bits),
        .wr_lock(wr_lock), .mem_lock(mem_lock), .umem_rd(umem_rd),
        .umem_hit(umem_hit), .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ack     <= 1'b0;
            wr_refused <= 1'b0;
            clr_pulse  <= 1'b0;
        end else begin
            wr_ack     <= wr_acc;
            wr_refused <= wr_en && bus_busy;
            clr_pulse  <= wr_acc && clr_ok && wr_addr == ADDR_W'(CLR_ADDR)
                          && wr_data == CLR_KEY;
        end
    end
endmodule

// File: rtl/trec_cmd_decoder_chk.sv
module trec_cmd_decoder_chk
    import trec_cmd_pkg::*;
(
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            wr_addr,
    input logic [DATA_W-1:0]            wr_data,
    input logic                         bus_busy,
    input logic                         rst_en_pin,
    input logic [ADDR_W-1:0]            rd_addr,
    input logic [DATA_W-1:0]            rd_data,
    input logic                         wr_ack,
    input logic                         wr_refused,
    input logic                         clr_pulse,
    input logic [TRIP_BYTES*DATA_W-1:0] trip_point,
    input logic [CFG_W-1:0]             cfg_bits,
    input logic                         wr_lock,
    input logic                         mem_lock
);
    AST_WLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lock |=> wr_lock); // R9
    AST_MLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_lock |=> mem_lock); // R9
    AST_WLOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_lock) |-> $past(wr_en && !bus_busy && wr_addr == ADDR_W'(WLK_ADDR)
                                 && wr_data == WLK_KEY)); // R5
    AST_MLOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_lock) |-> $past(wr_en && !bus_busy && wr_addr == ADDR_W'(MLK_ADDR)
                                  && wr_data == MLK_KEY)); // R6
    AST_CLR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |-> $past(wr_en && !bus_busy && wr_addr == ADDR_W'(CLR_ADDR)
                            && wr_data == CLR_KEY
                            && (cfg_bits[1] || (cfg_bits[2] && rst_en_pin)))); // R4
    AST_TRIP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lock |=> $stable(trip_point)); // R5
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lock |=> $stable(cfg_bits)); // R5
    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_busy) |=> (wr_refused && !wr_ack)); // R12
    AST_BUSY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_busy) |=> ($stable(cfg_bits) && $stable(trip_point))); // R12
    AST_ACK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ack && wr_refused)); // R12
    AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(CLR_ADDR) || rd_addr == ADDR_W'(WLK_ADDR)
         || rd_addr == ADDR_W'(MLK_ADDR)) |-> rd_data == '0); // R11
endmodule

bind trec_cmd_decoder trec_cmd_decoder_chk u_chk (.*);

// File: tb/trec_cmd_decoder_bench.sv
module trec_cmd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        bus_busy = 1'b0;
    logic        rst_en_pin = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        wr_ack, wr_refused, clr_pulse, wr_lock, mem_lock;
    logic [31:0] trip_point;
    logic [3:0]  cfg_bits;

    int n_run  = 0;
    int n_fail = 0;
    logic s_ack, s_ref, s_clr;

    always #5 clk = ~clk;

    trec_cmd_decoder u_trec_cmd_decoder (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; bus_busy = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive at negedge, sampled on posedge, pulses captured at next negedge
    task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic busy = 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; bus_busy = busy;
        @(negedge clk);
        s_ack = wr_ack; s_ref = wr_refused; s_clr = clr_pulse;
        wr_en = 1'b0; bus_busy = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 7 + 3);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] exp;
        do_reset();
        // R1 reset state
        chk("R1 trip", trip_point, 32'h0);
        chk("R1 cfg", {28'h0, cfg_bits}, 32'h0);
        chk("R1 locks", {30'h0, wr_lock, mem_lock}, 32'h0);
        chk("R1 pulses", {29'h0, wr_ack, wr_refused, clr_pulse}, 32'h0);
        for (int a = 0; a < 32; a++) begin
            rd(5'(a), v);
            chk("R1 read", {24'h0, v}, 32'h0);
        end

        // R2 R3 R11: write a pattern everywhere, read everything back
        for (int a = 0; a < 32; a++) begin
            wr(5'(a), pat(a));
            chk("R12 ack", {30'h0, s_ack, s_ref}, 32'h2);
        end
        for (int a = 0; a < 32; a++) begin
            rd(5'(a), v);
            if (a < 4 || (a >= 10 && a < 20)) exp = pat(a);
            else if (a == 4) exp = pat(a) & 8'h0F;
            else exp = 8'h00;
            chk((a < 5) ? "R2 readback" : (a >= 29) ? "R11 cmd read" : "R3 readback",
                {24'h0, v}, {24'h0, exp});
        end
        chk("R2 trip value", trip_point, {pat(3), pat(2), pat(1), pat(0)});
        chk("R11 locks untouched", {30'h0, wr_lock, mem_lock}, 32'h0);

        // R4: clear gating over enable bit, pin-mapped bit and pin
        for (int k = 0; k < 8; k++) begin
            logic re, pm, pin;
            re = k[0]; pm = k[1]; pin = k[2];
            wr(5'd4, {5'b0, pm, re, 1'b0});
            rst_en_pin = pin;
            wr(5'd29, 8'h55);
            chk("R4 clear gate", {31'h0, s_clr}, {31'h0, re | (pm & pin)});
            @(negedge clk);
            chk("R4 one cycle", {31'h0, clr_pulse}, 32'h0);
            wr(5'd29, 8'h54);
            chk("R4 wrong key", {31'h0, s_clr}, 32'h0);
        end
        rst_en_pin = 1'b0;

        // Phase A: write lock with an interrupted sequence
        do_reset();
        wr(5'd4, 8'h02);
        wr(5'd30, 8'hAA);
        wr(5'd5, 8'h00);
        wr(5'd30, 8'hAA);
        chk("R8 broken by other addr", {31'h0, wr_lock}, 32'h0);
        wr(5'd30, 8'hAB);
        wr(5'd30, 8'hAA);
        chk("R8 broken by other data", {31'h0, wr_lock}, 32'h0);
        wr(5'd30, 8'hAA);
        chk("R5 lock set", {31'h0, wr_lock}, 32'h1);
        wr(5'd4, 8'h0D);
        wr(5'd1, 8'h77);
        chk("R5 cfg frozen", {28'h0, cfg_bits}, 32'h2);
        chk("R5 trip frozen", trip_point, 32'h0);
        wr(5'd12, 8'h3C);
        rd(5'd12, v);
        chk("R7 umem free under wr_lock", {24'h0, v}, 32'h3C);
        wr(5'd29, 8'h55);
        chk("R10 clear under lock", {31'h0, s_clr}, 32'h1);
        wr(5'd30, 8'h00);
        chk("R9 wr_lock kept", {31'h0, wr_lock}, 32'h1);
        rd(5'd4, v);
        chk("R11 cfg read wr_lock", {24'h0, v}, 32'h12);

        // Phase B: memory lock, refused write in the middle
        do_reset();
        wr(5'd10, 8'h5A);
        wr(5'd31, 8'hF0);
        wr(5'd10, 8'h99, 1'b1);
        chk("R12 refused pulse", {30'h0, s_ack, s_ref}, 32'h1);
        rd(5'd10, v);
        chk("R12 refused no effect", {24'h0, v}, 32'h5A);
        wr(5'd31, 8'hF0);
        chk("R8 refused keeps arm", {31'h0, mem_lock}, 32'h1);
        chk("R6 wr_lock still clear", {31'h0, wr_lock}, 32'h0);
        wr(5'd10, 8'h11);
        wr(5'd19, 8'h22);
        rd(5'd10, v);
        chk("R6 umem frozen lo", {24'h0, v}, 32'h5A);
        rd(5'd19, v);
        chk("R6 umem frozen hi", {24'h0, v}, 32'h00);
        wr(5'd4, 8'h0A);
        wr(5'd3, 8'hC3);
        chk("R7 cfg free under mem_lock", {28'h0, cfg_bits}, 32'hA);
        chk("R7 trip free under mem_lock", trip_point, 32'hC300_0000);
        wr(5'd29, 8'h55);
        chk("R4 clear with enable", {31'h0, s_clr}, 32'h1);
        wr(5'd31, 8'h00);
        chk("R9 mem_lock kept", {31'h0, mem_lock}, 32'h1);
        rd(5'd4, v);
        chk("R11 cfg read mem_lock", {24'h0, v}, 32'h2A);
        rd(5'd31, v);
        chk("R11 cmd read zero", {24'h0, v}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule